// File: doc/BRIEF.md
# Converter Power Mode Sequencer

This block is the control state machine for a two-channel sampling converter. It watches an active-low power-down input and a two-bit sleep bus, and it decides, cycle by cycle, which channel is powered and which channel is producing trustworthy samples. Analog settling is stood in for by counters. A deep power-down costs a long reference-settling wait when it ends. A light sleep costs only a short per-channel wait. In both cases the wait is followed by a pipeline-fill interval before the first real sample reaches the output.

After the supply comes up, the converter must see power-down asserted on at least one clock edge before any channel may run. Until that happens, a status output reports the block as uninitialised and every channel enable stays low. Power-down overrides every other control. While it is low, all outputs read zero in the same cycle and the internal reference-settling count restarts. Valid drops at once when a channel's request goes away. It returns only after the full wake-up count and the pipeline fill have both elapsed again.

Requirements: the sleep-wake count `SLP_WAKE` must be at least 2, and the pipeline latency `PIPE_LAT` must be at least 1.

Top module: `pwr_mode_seq`

## Requirements
- R1: While `pd_ni` is low, `chan_en_o`, `chan_vld_o` and `uninit_o` are all zero in that same cycle, whatever the sleep bus holds.
- R2: Bit 0 of `slp_i` requests channel 0 and bit 1 requests channel 1: 00 puts both channels to sleep, 01 runs channel 0 only, 10 runs channel 1 only, 11 runs both.
- R3: Once `pwr_good_i` is high, `uninit_o` stays high and both enables stay low until a rising edge samples `pd_ni` low. That edge clears the uninitialised state for good.
- R4: When power-down is released with a channel already requested, that channel's valid first reads high after the (PD_WAKE+PIPE_LAT)-th rising edge that samples `pd_ni` high.
- R5: When the references have already settled, a channel woken from sleep shows valid after the (SLP_WAKE+PIPE_LAT)-th edge, counting from the edge that first samples its request.
- R6: A channel's enable goes high after the first edge that samples its request while initialised, and it stays high while that request is held. Valid is never high without enable.
- R7: When a channel's request is removed, its enable and valid go low in that same cycle. A later request restarts the full wake-up and fill count.
- R8: Suppose a channel is first requested on the m-th edge after power-down release. Its valid then rises after edge max(m+SLP_WAKE-1, PD_WAKE)+PIPE_LAT.
- R9: Each channel's enable and valid depend only on its own sleep bit, given the shared power-down and initialisation state.
- R10: `pwr_good_i` low resets the block asynchronously to the uninitialised state, with all enables and valids low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock; only the rising edge is used |
| pwr_good_i | input | 1 | Supply-stable indication; low acts as asynchronous reset |
| pd_ni | input | 1 | Full power-down request, active low |
| slp_i | input | NCH | Per-channel run request; a 0 bit puts that channel to sleep |
| chan_en_o | output | NCH | Per-channel power enable |
| chan_vld_o | output | NCH | Per-channel sample-valid flag |
| uninit_o | output | 1 | High while the mandatory power-down reset has not yet been seen |

## Verification
The bench builds the block with NCH=2, PD_WAKE=9, SLP_WAKE=4 and PIPE_LAT=3. With these values a full power-down recovery is only twelve edges long. That makes it cheap to sweep the first request of a channel across every edge offset inside and just beyond the reference-settling window, which covers both branches of the max() in R8. It also makes it cheap to step the sleep bus through all sixteen transitions between its four codes.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

    typedef enum logic [1:0] {
        CH_OFF  = 2'd0,
        CH_WAKE = 2'd1,
        CH_FILL = 2'd2,
        CH_RUN  = 2'd3
    } ch_state_e;

endpackage

// File: rtl/pms_ref_track.sv
module pms_ref_track #(
    parameter int PD_WAKE = 900
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pd_ni,
    output logic uninit_o,
    output logic ref_rdy_o,
    output logic ref_ok_o
);
    localparam int RW = (PD_WAKE > 1) ? $clog2(PD_WAKE) : 1;
    localparam logic [RW-1:0] RLOAD = RW'(PD_WAKE - 1);

    typedef struct packed {
        logic          uninit;
        logic          rdy;
        logic [RW-1:0] cnt;
    } ref_t;

    ref_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (!pd_ni) begin
            // power-down: init seen, references restart settling
            r_d.uninit = 1'b0;
            r_d.rdy    = 1'b0;
            r_d.cnt    = RLOAD;
        end else if (!r_q.uninit && !r_q.rdy) begin
            if (r_q.cnt == '0) r_d.rdy = 1'b1;
            else               r_d.cnt = r_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= '{uninit: 1'b1, rdy: 1'b0, cnt: RLOAD};
        else         r_q <= r_d;
    end

    assign uninit_o  = r_q.uninit;
    assign ref_rdy_o = r_q.rdy;
    // settled now, or settling completes on the coming edge
    assign ref_ok_o  = r_q.rdy | (pd_ni & ~r_q.uninit & (r_q.cnt == '0));

    assert_pd_clears_init_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !pd_ni |=> !uninit_o);

    assert_rdy_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ref_rdy_o && pd_ni) |=> ref_rdy_o);

endmodule

// File: rtl/pms_chan_ctl.sv
module pms_chan_ctl
    import pwr_seq_pkg::*;
#(
    parameter int SLP_WAKE = 20,
    parameter int PIPE_LAT = 12
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic go_i,
    input  logic ref_ok_i,
    output logic en_o,
    output logic vld_o
);
    localparam int CMAX = (SLP_WAKE > PIPE_LAT) ? SLP_WAKE : PIPE_LAT;
    localparam int CW   = (CMAX > 1) ? $clog2(CMAX) : 1;
    // entry edge already counts as the first wake edge
    localparam logic [CW-1:0] WLOAD = CW'(SLP_WAKE - 2);
    localparam logic [CW-1:0] FLOAD = CW'(PIPE_LAT - 1);

    typedef struct packed {
        ch_state_e     st;
        logic [CW-1:0] cnt;
    } ch_t;

    ch_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (!go_i) begin
            c_d.st  = CH_OFF;
            c_d.cnt = '0;
        end else begin
            unique case (c_q.st)
                CH_OFF: begin
                    c_d.st  = CH_WAKE;
                    c_d.cnt = WLOAD;
                end
                CH_WAKE: begin
                    if (c_q.cnt != '0) begin
                        c_d.cnt = c_q.cnt - 1'b1;
                    end else if (ref_ok_i) begin
                        c_d.st  = CH_FILL;
                        c_d.cnt = FLOAD;
                    end
                end
                CH_FILL: begin
                    if (c_q.cnt != '0) c_d.cnt = c_q.cnt - 1'b1;
                    else               c_d.st  = CH_RUN;
                end
                default: c_d = c_q;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) c_q <= '{st: CH_OFF, cnt: '0};
        else         c_q <= c_d;
    end

    assign en_o  = go_i & (c_q.st != CH_OFF);
    assign vld_o = go_i & (c_q.st == CH_RUN);

    assert_en_entry_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (c_q.st != CH_OFF) |-> $past(go_i));

    assert_run_order_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (c_q.st == CH_RUN) |-> ($past(c_q.st) == CH_FILL || $past(c_q.st) == CH_RUN));

endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq #(
    parameter int NCH      = 2,
    parameter int PD_WAKE  = 900,
    parameter int SLP_WAKE = 20,
    parameter int PIPE_LAT = 12
) (
    input  logic           clk_i,
    input  logic           pwr_good_i,
    input  logic           pd_ni,
    input  logic [NCH-1:0] slp_i,
    output logic [NCH-1:0] chan_en_o,
    output logic [NCH-1:0] chan_vld_o,
    output logic           uninit_o
);
    logic           uninit_q;
    logic           ref_rdy;
    logic           ref_ok;
    logic [NCH-1:0] go;

    pms_ref_track #(.PD_WAKE(PD_WAKE)) u_ref (
        .clk_i     (clk_i),
        .rst_ni    (pwr_good_i),
        .pd_ni     (pd_ni),
        .uninit_o  (uninit_q),
        .ref_rdy_o (ref_rdy),
        .ref_ok_o  (ref_ok)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        assign go[c] = pd_ni & ~uninit_q & slp_i[c];

        pms_chan_ctl #(.SLP_WAKE(SLP_WAKE), .PIPE_LAT(PIPE_LAT)) u_chan (
            .clk_i    (clk_i),
            .rst_ni   (pwr_good_i),
            .go_i     (go[c]),
            .ref_ok_i (ref_ok),
            .en_o     (chan_en_o[c]),
            .vld_o    (chan_vld_o[c])
        );
    end

    assign uninit_o = uninit_q & pd_ni;

    assert_vld_implies_en_R6: assert property (@(posedge clk_i) disable iff (!pwr_good_i)
        (chan_vld_o & ~chan_en_o) == '0);

    assert_uninit_gates_R3: assert property (@(posedge clk_i) disable iff (!pwr_good_i)
        uninit_o |-> (chan_en_o == '0));

    assert_vld_after_ref_R4: assert property (@(posedge clk_i) disable iff (!pwr_good_i)
        (chan_vld_o != '0) |-> ref_rdy);

endmodule

// File: tb/pwr_mode_seq_bench.sv
module pwr_mode_seq_bench;
    localparam int NCH = 2;
    localparam int PDW = 9;
    localparam int SLW = 4;
    localparam int PIP = 3;

    logic           clk = 1'b0;
    logic           pg  = 1'b0;
    logic           pd  = 1'b1;
    logic [NCH-1:0] slp = '0;
    logic [NCH-1:0] en, vld;
    logic           uninit;

    int checks = 0;
    int errors = 0;

    // bench-side model state
    bit u_e = 1'b1;
    int ph  = 0;
    int ent [NCH];
    bit pgo [NCH];

    always #4 clk = ~clk;

    pwr_mode_seq #(.NCH(NCH), .PD_WAKE(PDW), .SLP_WAKE(SLW), .PIPE_LAT(PIP)) u_pwr_mode_seq (
        .clk_i      (clk),
        .pwr_good_i (pg),
        .pd_ni      (pd),
        .slp_i      (slp),
        .chan_en_o  (en),
        .chan_vld_o (vld),
        .uninit_o   (uninit)
    );

    task automatic cmp(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic step(input string tag);
        logic [NCH-1:0] en_e, vld_e;
        @(posedge clk);
        if (!pg) begin
            u_e = 1'b1;
            ph  = 0;
            for (int c = 0; c < NCH; c++) pgo[c] = 1'b0;
        end else begin
            if (pd && !u_e) ph++;
            else            ph = 0;
            for (int c = 0; c < NCH; c++) begin
                bit g;
                g = pd && !u_e && slp[c];
                if (g && !pgo[c]) ent[c] = ph;
                pgo[c] = g;
            end
            if (!pd) u_e = 1'b0;
        end
        #2;
        for (int c = 0; c < NCH; c++) begin
            int done;
            done     = (ent[c] + SLW - 1 > PDW) ? ent[c] + SLW - 1 : PDW;
            en_e[c]  = pg && pgo[c];
            vld_e[c] = pg && pgo[c] && (ph >= done + PIP);
        end
        cmp(tag, "uninit", int'(uninit), int'(u_e && pd));
        cmp(tag, "en", int'(en), int'(en_e));
        cmp(tag, "vld", int'(vld), int'(vld_e));
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stim
        for (int c = 0; c < NCH; c++) begin ent[c] = 0; pgo[c] = 1'b0; end
        // R10: held in reset
        repeat (3) step("R10");
        // R3: supply good, no power-down yet, channels requested but blocked
        pg = 1'b1; slp = 2'b11;
        repeat (5) step("R3");
        // R4: mandatory power-down then release with both requested
        pd = 1'b0; step("R3");
        pd = 1'b1;
        repeat (PDW + PIP + 4) step("R4");
        // R2/R5/R6: every sleep-bus transition
        for (int a = 0; a < 4; a++) begin
            for (int b = 0; b < 4; b++) begin
                slp = 2'(a);
                repeat (SLW + PIP + 2) step("R2");
                slp = 2'(b);
                step("R6");
                repeat (SLW + PIP + 1) step("R5");
            end
        end
        // R9: channel 0 steady while channel 1 toggles
        slp = 2'b01;
        repeat (SLW + PIP + 2) step("R9");
        for (int k = 0; k < 3; k++) begin
            slp = 2'b11; repeat (k + 2) step("R9");
            slp = 2'b01; repeat (2) step("R9");
        end
        // R7: same-cycle drop, then full restart
        slp = 2'b11;
        repeat (SLW + PIP + 2) step("R7");
        slp = 2'b01;
        #1;
        cmp("R7", "ch1 en", int'(en[1]), 0);
        cmp("R7", "ch1 vld", int'(vld[1]), 0);
        cmp("R7", "ch0 vld", int'(vld[0]), 1);
        step("R7");
        slp = 2'b11;
        repeat (SLW + PIP + 2) step("R7");
        // R1: power-down mid-cycle zeros everything, sleep bus ignored
        pd = 1'b0;
        #1;
        cmp("R1", "en", int'(en), 0);
        cmp("R1", "vld", int'(vld), 0);
        cmp("R1", "uninit", int'(uninit), 0);
        step("R1");
        slp = 2'b10; step("R1");
        slp = 2'b01; step("R1");
        // R8: first request of channel 1 swept across the settling window
        for (int m = 1; m <= PDW + 2; m++) begin
            pd = 1'b0; slp = 2'b01; step("R8");
            pd = 1'b1;
            repeat (m - 1) step("R8");
            slp = 2'b11;
            repeat (PDW + SLW + PIP + 2) step("R8");
        end
        // R10: supply loss returns to uninitialised
        pg = 1'b0;
        #1;
        cmp("R10", "en", int'(en), 0);
        cmp("R10", "vld", int'(vld), 0);
        repeat (2) step("R10");
        pg = 1'b1;
        repeat (4) step("R10");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule